// File: doc/BRIEF.md
# Quasiresonant Valley-Switching Gate Controller

This block decides, clock by clock, when the power switch of a free-running flyback converter turns on and off. Analog comparators outside the block turn the converter's sense voltages into synchronised single-bit flags. Those flags report that the demagnetisation winding has dropped below the zero-crossing level, that it sits above the blanking-select level, and that the simulated primary current has reached the feedback level. Further flags report protection events. From these flags and a 4-bit valley target the block produces one registered gate-drive bit.

The switch turns on in a valley of the drain ringing. After each turn-off, the block counts the falling crossings of the zero-crossing level and fires on the crossing whose number equals the target. The target is held in a register elsewhere. A suppression window follows each turn-off and hides the first ringing. Its length is chosen by the winding level at the moment of turn-off. A restart timer fires the switch when no crossing arrives, and this sets a floor on the switching frequency. Overvoltage, fault-comparator and mains-undervoltage events latch the gate off until the supply drops below its reset level.

Top module: `qr_valley_ctrl`

## Requirements
- R1: A falling crossing is a rising edge of `zc_low`. It is counted only while the gate is off, no suppression window is running and nothing holds the gate off. Each such crossing raises the crossing count by exactly one, and the count saturates at 15.
- R2: The gate rises on the clock edge that counts the crossing whose number equals `valley_target`. A target of 0 behaves as a target of 1.
- R3: While `zc_low` is 0, the gate is low from the next clock edge onward and cannot be turned on, by a crossing or by a restart.
- R4: Once on, the gate stays high for at least MIN_ON clock cycles unless a hold-off condition (R3, R7, R8, R10) applies. It falls on the edge after `cs_trip` is seen once that minimum has been served.
- R5: Every falling edge of the gate starts a suppression window. The window is BLANK_SHORT cycles if `zc_high` is 1 in the cycle of the turn-off, and BLANK_LONG cycles otherwise. The gate cannot rise earlier than window+1 edges after the turn-off edge. Crossings inside the window are not counted.
- R6: If `zc_low` stays 1 while the gate is off, the gate rises RESTART edges after the first edge that saw that state, provided no suppression window or hold-off applies. Any cycle with `zc_low` at 0 restarts that interval.
- R7: A cycle with `ovp` or `fault` at 1 drives the gate low on the next edge and sets a protection latch. The latch keeps the gate low and clears only on a cycle with `supply_low` at 1.
- R8: `mains_uv` is sampled only while the gate is off. A 1 seen then latches the gate off until a `supply_low` cycle. A 1 seen while the gate is on has no effect.
- R9: The crossing count restarts from zero at every turn-on. Each off period therefore needs a fresh run of crossings to reach the target.
- R10: `inhibit` at 1 holds the gate low from the next edge and does not latch. Crossings seen under inhibit are not counted.
- R11: After a synchronous reset the gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_low | input | 1 | Winding voltage below the zero-crossing level |
| zc_high | input | 1 | Winding voltage above the blanking-select level |
| cs_trip | input | 1 | Simulated primary current has reached the feedback level |
| ovp | input | 1 | Supply overvoltage event |
| fault | input | 1 | Fault comparator event |
| mains_uv | input | 1 | Mains undervoltage flag |
| supply_low | input | 1 | Supply below its reset level; clears the latches and holds the gate off |
| inhibit | input | 1 | External non-latching gate hold-off |
| valley_target | input | 4 | Crossing number on which to turn on (0 treated as 1) |
| gate | output | 1 | Registered gate drive |

## Verification
The bench aims at the edges of the suppression window. It places a crossing after a short window would have ended but inside a long one. A design that chose the window length from the wrong level, or sampled it at the wrong time, would switch there. It also checks that crossings swallowed by the window, by inhibit or by a protection latch leave the count untouched. A counter that kept them would turn on one valley early or miss the target altogether. Other tests cut the restart interval with a single high cycle on the winding, hold the count across a turn-on, and pulse `mains_uv` while the switch is on. Each of these exposes a timer that fails to restart, a counter that keeps stale crossings, or a latch that samples at the wrong time.

// File: rtl/qrv_pkg.sv
package qrv_pkg;
  localparam int ZC_W = 4;
  typedef logic [ZC_W-1:0] zc_cnt_t;

  function automatic zc_cnt_t eff_target(input zc_cnt_t t);
    return (t == '0) ? zc_cnt_t'(1) : t;
  endfunction
endpackage

// File: rtl/qrv_valley_counter.sv
module qrv_valley_counter (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        inc,
  input  logic [qrv_pkg::ZC_W-1:0]    target,
  output logic                        hit
);
  import qrv_pkg::*;

  zc_cnt_t cnt;
  zc_cnt_t nxt;

  assign nxt = (cnt == '1) ? cnt : cnt + 1'b1;
  assign hit = inc && (nxt == eff_target(target));

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc)
      cnt <= nxt;
  end

  AST_ZC_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == zc_cnt_t'($past(cnt) + 1'b1))); // R1
endmodule

// File: rtl/qrv_blank_timer.sv
module qrv_blank_timer #(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sel_short,
  output logic busy
);
  localparam int BMAX = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int BW   = $clog2(BMAX + 1);
  localparam logic [BW-1:0] SHORT_V = BW'(SHORT_CYC);
  localparam logic [BW-1:0] LONG_V  = BW'(LONG_CYC);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (start)
      cnt <= sel_short ? SHORT_V : LONG_V;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_BLANK_LOADS: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R5
endmodule

// File: rtl/qrv_restart_timer.sv
module qrv_restart_timer #(
  parameter int PERIOD = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic due
);
  localparam int RW = $clog2(PERIOD);
  localparam logic [RW-1:0] LAST = RW'(PERIOD - 1);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  assign due = arm && (cnt == LAST);

  AST_RESTART_ARMED: assert property (@(posedge clk) disable iff (rst)
    due |-> $past(arm)); // R6
endmodule

// File: rtl/qrv_prot.sv
module qrv_prot (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic mains_uv,
  input  logic gate_on,
  input  logic supply_low,
  output logic block,
  output logic prot_q,
  output logic uv_q
);
  logic prot_d;
  logic uv_d;

  assign prot_d = supply_low ? 1'b0 : (prot_q | trip);
  assign uv_d   = supply_low ? 1'b0 : (uv_q | (mains_uv & ~gate_on));
  assign block  = prot_d | uv_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= 1'b0;
      uv_q   <= 1'b0;
    end else begin
      prot_q <= prot_d;
      uv_q   <= uv_d;
    end
  end

  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (prot_q && !supply_low) |=> prot_q); // R7
  AST_UV_STICKY: assert property (@(posedge clk) disable iff (rst)
    (uv_q && !supply_low) |=> uv_q); // R8
endmodule

// File: rtl/qr_valley_ctrl.sv
module qr_valley_ctrl #(
  parameter int MIN_ON      = 3,
  parameter int BLANK_SHORT = 4,
  parameter int BLANK_LONG  = 12,
  parameter int RESTART     = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     zc_low,
  input  logic                     zc_high,
  input  logic                     cs_trip,
  input  logic                     ovp,
  input  logic                     fault,
  input  logic                     mains_uv,
  input  logic                     supply_low,
  input  logic                     inhibit,
  input  logic [qrv_pkg::ZC_W-1:0] valley_target,
  output logic                     gate
);
  logic gate_q, gate_d;
  logic zc_prev, zc_edge;
  logic blank_busy, restart_due, valley_hit;
  logic latch_block, prot_q, uv_q;
  logic hold_off, start_ok, count_en, turn_off, min_met;

  assign zc_edge  = zc_low & ~zc_prev;
  assign hold_off = latch_block | supply_low | ~zc_low | inhibit;
  assign start_ok = ~gate_q & ~blank_busy & ~hold_off;
  assign count_en = zc_edge & start_ok;

  generate
    if (MIN_ON <= 1) begin : g_no_min
      assign min_met = 1'b1;
    end else begin : g_min
      localparam int ON_W = $clog2(MIN_ON);
      localparam logic [ON_W-1:0] ON_LAST = ON_W'(MIN_ON - 1);
      logic [ON_W-1:0] on_cnt;
      always_ff @(posedge clk) begin
        if (rst || !gate_q)
          on_cnt <= '0;
        else if (on_cnt != ON_LAST)
          on_cnt <= on_cnt + 1'b1;
      end
      assign min_met = (on_cnt == ON_LAST);
    end
  endgenerate

  always_comb begin
    if (hold_off)
      gate_d = 1'b0;
    else if (gate_q)
      gate_d = ~(cs_trip & min_met);
    else
      gate_d = start_ok & (valley_hit | restart_due);
  end

  assign turn_off = gate_q & ~gate_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      zc_prev <= 1'b1;
    end else begin
      gate_q  <= gate_d;
      zc_prev <= zc_low;
    end
  end

  assign gate = gate_q;

  qrv_valley_counter u_count (
    .clk(clk), .rst(rst), .clr(gate_q), .inc(count_en),
    .target(valley_target), .hit(valley_hit)
  );

  qrv_blank_timer #(.SHORT_CYC(BLANK_SHORT), .LONG_CYC(BLANK_LONG)) u_blank (
    .clk(clk), .rst(rst), .start(turn_off), .sel_short(zc_high), .busy(blank_busy)
  );

  qrv_restart_timer #(.PERIOD(RESTART)) u_restart (
    .clk(clk), .rst(rst), .arm(~gate_q & zc_low), .due(restart_due)
  );

  qrv_prot u_prot (
    .clk(clk), .rst(rst), .trip(ovp | fault), .mains_uv(mains_uv),
    .gate_on(gate_q), .supply_low(supply_low), .block(latch_block),
    .prot_q(prot_q), .uv_q(uv_q)
  );

  AST_HIGH_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    !zc_low |=> !gate); // R3
  AST_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
    (gate_q && !min_met && !hold_off) |=> gate_q); // R4
  AST_BLANK_NO_ON: assert property (@(posedge clk) disable iff (rst)
    blank_busy |=> !gate_q); // R5
  AST_LATCH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (prot_q || uv_q) |-> !gate_q); // R7
  AST_UV_ONLY_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(uv_q) |-> !$past(gate_q)); // R8
  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !gate); // R10
endmodule

// File: tb/qr_valley_ctrl_tb.sv
`timescale 1ns/1ps
module qr_valley_ctrl_tb;
  localparam int MIN_ON = 3, BS = 4, BL = 12, RS = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic zc_low = 1'b0, zc_high = 1'b0, cs_trip = 1'b0, ovp = 1'b0, fault = 1'b0;
  logic mains_uv = 1'b0, supply_low = 1'b0, inhibit = 1'b0;
  logic [3:0] valley_target = 4'd1;
  logic gate;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qr_valley_ctrl #(.MIN_ON(MIN_ON), .BLANK_SHORT(BS), .BLANK_LONG(BL), .RESTART(RS)) u_dut (
    .clk(clk), .rst(rst), .zc_low(zc_low), .zc_high(zc_high), .cs_trip(cs_trip),
    .ovp(ovp), .fault(fault), .mains_uv(mains_uv), .supply_low(supply_low),
    .inhibit(inhibit), .valley_target(valley_target), .gate(gate)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string req, input string what);
    n_chk++;
    if (gate !== exp) begin
      n_bad++;
      $display("FAIL %s %s: gate=%b expected %b", req, what, gate, exp);
    end
  endtask

  task automatic valley();
    zc_low = 1'b0; step(1);
    zc_low = 1'b1; step(1);
  endtask

  task automatic turn_off(input logic hi);
    cs_trip = 1'b1; zc_high = hi;
    for (int i = 0; i < 10 && gate === 1'b1; i++) step(1);
    cs_trip = 1'b0; zc_high = 1'b0; zc_low = 1'b0;
  endtask

  task automatic supply_pulse();
    zc_low = 1'b0; supply_low = 1'b1; step(1);
    supply_low = 1'b0; step(1);
  endtask

  task automatic t_reset();
    zc_low = 1'b1;
    step(5);
    chk(1'b0, "R11", "gate during reset");
    zc_low = 1'b0; rst = 1'b0; step(2);
    chk(1'b0, "R11", "gate after reset");
  endtask

  task automatic t_nth_valley();
    valley_target = 4'd3;
    valley(); chk(1'b0, "R1", "after crossing 1 of 3");
    valley(); chk(1'b0, "R1", "after crossing 2 of 3");
    valley(); chk(1'b1, "R2", "on at crossing 3");
    cs_trip = 1'b1; zc_high = 1'b1;
    step(1); chk(1'b1, "R4", "min on-time cycle 2");
    step(1); chk(1'b1, "R4", "min on-time cycle 3");
    step(1); chk(1'b0, "R4", "off after min on-time");
    cs_trip = 1'b0; zc_high = 1'b0; zc_low = 1'b0;
  endtask

  task automatic t_short_blank();
    valley_target = 4'd2;
    valley(); chk(1'b0, "R5", "crossing inside short window");
    step(6);
    valley(); chk(1'b0, "R5", "blanked crossing was not counted");
    valley(); chk(1'b1, "R5", "on at second counted crossing");
  endtask

  task automatic t_count_clear();
    turn_off(1'b1); step(5);
    valley(); chk(1'b0, "R9", "count restarted after turn-on");
    valley(); chk(1'b1, "R9", "on at target after restart of count");
  endtask

  task automatic t_long_blank();
    valley_target = 4'd1;
    turn_off(1'b0); step(5);
    valley(); chk(1'b0, "R5", "crossing inside long window");
    step(8);
    valley(); chk(1'b1, "R5", "on after long window");
  endtask

  task automatic t_restart();
    valley_target = 4'd15;
    turn_off(1'b1); step(6);
    zc_low = 1'b1;
    step(RS - 1); chk(1'b0, "R6", "one cycle before restart");
    step(1);      chk(1'b1, "R6", "restart pulse");
    turn_off(1'b1); step(6);
    zc_low = 1'b1; step(RS - 5);
    zc_low = 1'b0; step(1);
    zc_low = 1'b1;
    step(RS - 1); chk(1'b0, "R6", "interval restarted by high input");
    step(1);      chk(1'b1, "R6", "restart after full new interval");
  endtask

  task automatic t_target_zero();
    turn_off(1'b1); step(6);
    valley_target = 4'd0;
    valley(); chk(1'b1, "R2", "target 0 acts as 1");
  endtask

  task automatic t_protection();
    ovp = 1'b1; step(1); ovp = 1'b0;
    chk(1'b0, "R7", "ovp turns gate off");
    zc_low = 1'b0; valley_target = 4'd1; step(15);
    valley(); chk(1'b0, "R7", "crossing blocked by ovp latch");
    step(RS + 2); chk(1'b0, "R7", "restart blocked by ovp latch");
    supply_pulse();
    valley(); chk(1'b1, "R7", "on after latch cleared");
    turn_off(1'b1); step(6);
    fault = 1'b1; step(1); fault = 1'b0;
    valley(); chk(1'b0, "R7", "crossing blocked by fault latch");
    supply_pulse();
    valley(); chk(1'b1, "R7", "on after fault latch cleared");
  endtask

  task automatic t_mains();
    mains_uv = 1'b1; step(1); mains_uv = 1'b0;
    chk(1'b1, "R8", "mains flag ignored while on");
    turn_off(1'b1); step(6);
    mains_uv = 1'b1; step(1); mains_uv = 1'b0;
    valley(); chk(1'b0, "R8", "mains flag latched during off");
    supply_pulse();
    valley(); chk(1'b1, "R8", "on after mains latch cleared");
  endtask

  task automatic t_inhibit();
    inhibit = 1'b1; step(1); inhibit = 1'b0;
    chk(1'b0, "R10", "inhibit turns gate off");
    zc_low = 1'b0; step(15);
    valley_target = 4'd2;
    inhibit = 1'b1;
    valley(); chk(1'b0, "R10", "crossing under inhibit");
    inhibit = 1'b0;
    valley(); chk(1'b0, "R10", "inhibited crossing not counted");
    valley(); chk(1'b1, "R10", "on after inhibit released");
  endtask

  task automatic t_held_off();
    zc_low = 1'b0; step(1);
    chk(1'b0, "R3", "input above level turns gate off");
    step(RS + 20);
    chk(1'b0, "R3", "no restart while input above level");
  endtask

  initial begin
    t_reset();
    t_nth_valley();
    t_short_blank();
    t_count_clear();
    t_long_blank();
    t_restart();
    t_target_zero();
    t_protection();
    t_mains();
    t_inhibit();
    t_held_off();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule